// File: doc/BRIEF.md
# E1 Receive Parity Bit Inserter

This block sits on the receive-side system data path of an E1 framer. The serial stream moves one bit per clock and is organised as 256-bit basic frames. A frame-start pulse marks the first bit of timeslot 0. The block can overwrite that single bit with one of two values. The first is a parity bit computed over the whole previous basic frame. The second is a programmed fixed level. Every other bit passes through unchanged.

A two-bit drive field decides whether the serial outputs are driven or left floating. All configuration inputs are static levels. With every input at 0, insertion is off, the bit passes through, and the outputs float. The modified data and the drive enable are both registered, so they appear one clock after the input bit.

Top module: `e1_parity_inserter`

## Requirements
- R1: Every bit that is not a frame-start bit appears unchanged on `sd_out` exactly one clock after it is presented on `sd_in`.
- R2: With `par_on`=1 and `par_odd`=0, the frame-start output bit is 1 when the previous complete frame, as emitted on `sd_out`, held an odd number of ones, and 0 otherwise.
- R3: With `par_on`=1 and `par_odd`=1, the frame-start output bit is 1 when that count of ones was even, and 0 otherwise.
- R4: `par_ext`=0 leaves the frame-start bit out of the count. `par_ext`=1 counts that bit as it was emitted, including an inserted value.
- R5: With `par_on`=0 and `fix_on`=1, the frame-start output bit equals `fix_lvl`.
- R6: With `par_on`=0 and `fix_on`=0, the frame-start bit passes through unchanged.
- R7: After reset, with `par_on`=1, the inserted bit is 0 until a frame of exactly 256 bits has closed between two frame-start pulses.
- R8: Frame alignment is lost in two cases: a frame-start pulse arrives before 256 bits have elapsed, or no pulse arrives when bit 256 is due. After either, the next inserted parity bit is 0, and correct parity resumes once a full 256-bit frame has closed.
- R9: `sd_oe` is 1 only when `drv_mode` is 2'b01. Code 2'b00 and the unused codes 2'b10 and 2'b11 give 0. `sd_oe` has the same one-clock latency as the data.
- R10: While `rst_n` is low, `sd_out` and `sd_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | High during the first bit of timeslot 0 |
| sd_in | input | 1 | Serial receive data |
| par_on | input | 1 | Parity insertion enable |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| par_ext | input | 1 | Include the frame-start bit in the parity count |
| fix_on | input | 1 | Force the frame-start bit when parity is off |
| fix_lvl | input | 1 | Forced level |
| drv_mode | input | 2 | Output drive code |
| sd_out | output | 1 | Serial output data, one clock of latency |
| sd_oe | output | 1 | Output drive enable, one clock of latency |

## Verification
The bench targets the parity seam between two frames:
- A design that counts over the current frame instead of the previous one, or that inverts the odd and even rule, produces wrong bits on `sd_out`.
- A design that takes the frame-start bit from the input rather than from the emitted value when `par_ext` is set also produces wrong bits.

Alignment faults are exercised with a short frame and with a missing pulse. A design that keeps stale parity across such a fault emits a 1 where 0 is required. The two unused drive codes are applied, so a decoder that treats them as drive is caught on `sd_oe`.

// File: rtl/e1_parity_inserter.sv
module e1_parity_inserter #(
  parameter int FRAME_BITS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       sd_in,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       par_ext,
  input  logic       fix_on,
  input  logic       fix_lvl,
  input  logic [1:0] drv_mode,
  output logic       sd_out,
  output logic       sd_oe
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] pos_q;
  logic          aligned_q, acc_q, out_q, oe_q;

  wire at_end   = (pos_q == LAST);
  wire full_frm = aligned_q && at_end;
  wire par_bit  = full_frm & (acc_q ^ par_odd);
  wire first_b  = par_on ? par_bit : (fix_on ? fix_lvl : sd_in);
  wire next_out = frm_start ? first_b : sd_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
      acc_q     <= 1'b0;
      out_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      out_q <= next_out;
      oe_q  <= (drv_mode == 2'b01);
      if (frm_start) begin
        pos_q     <= '0;
        aligned_q <= 1'b1;
        acc_q     <= par_ext & first_b;
      end else begin
        pos_q <= at_end ? '0 : pos_q + CW'(1);
        acc_q <= acc_q ^ sd_in;
        if (at_end) aligned_q <= 1'b0;
      end
    end
  end

  assign sd_out = out_q;
  assign sd_oe  = oe_q;

  // R1
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> (sd_out == $past(sd_in)));
  // R5
  fixed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !par_on && fix_on) |=> (sd_out == $past(fix_lvl)));
  // R6
  first_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !par_on && !fix_on) |=> (sd_out == $past(sd_in)));
  // R7
  no_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && par_on && !aligned_q) |=> !sd_out);
  // R9
  float_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_mode != 2'b01) |=> !sd_oe);
endmodule

// File: tb/e1_parity_inserter_tb.sv
module e1_parity_inserter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, sd_in = 1'b0;
  logic par_on = 1'b0, par_odd = 1'b0, par_ext = 1'b0, fix_on = 1'b0, fix_lvl = 1'b0;
  logic [1:0] drv_mode = 2'b00;
  logic sd_out, sd_oe;

  logic c_par_on = 0, c_par_odd = 0, c_par_ext = 0, c_fix_on = 0, c_fix_lvl = 0;
  logic [1:0] c_drv = 2'b00;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  int  m_pos = 0, m_ones = 0;
  bit  m_seen = 0, m_ever = 0;
  bit  pend = 0;
  logic exp_d, exp_oe;
  string exp_tag;

  always #10 clk = ~clk;

  e1_parity_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .sd_in(sd_in),
    .par_on(par_on), .par_odd(par_odd), .par_ext(par_ext),
    .fix_on(fix_on), .fix_lvl(fix_lvl), .drv_mode(drv_mode),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cyc(input bit f, input logic d);
    bit valid;
    logic ins, o;
    @(negedge clk);
    cycles++;
    if (pend) begin
      chk(exp_tag, sd_out, exp_d);
      chk("R9", sd_oe, exp_oe);
    end
    frm_start = f; sd_in = d;
    par_on = c_par_on; par_odd = c_par_odd; par_ext = c_par_ext;
    fix_on = c_fix_on; fix_lvl = c_fix_lvl; drv_mode = c_drv;
    exp_oe = (c_drv == 2'b01);
    if (f) begin
      valid = m_seen && (m_pos == 255);
      ins = valid ? logic'((m_ones % 2) ^ int'(c_par_odd)) : 1'b0;
      o = c_par_on ? ins : (c_fix_on ? c_fix_lvl : d);
      if (!c_par_on) exp_tag = c_fix_on ? "R5" : "R6";
      else if (!valid) exp_tag = m_ever ? "R8" : "R7";
      else if (c_par_ext) exp_tag = "R4";
      else exp_tag = c_par_odd ? "R3" : "R2";
      m_ones = (c_par_ext && o) ? 1 : 0;
      m_pos = 0; m_seen = 1; m_ever = 1;
    end else begin
      if (m_seen && m_pos == 255) m_seen = 0;
      m_pos = (m_pos + 1) % 256;
      m_ones += int'(d);
      o = d;
      exp_tag = "R1";
    end
    exp_d = o;
    pend = 1;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) cyc(i == 0, logic'($urandom_range(0, 1)));
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, logic'($urandom_range(0, 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", sd_out, 1'b0);
    chk("R10", sd_oe, 1'b0);
    rst_n = 1'b1;
    frame(256); frame(256);                                   // R6, outputs floating
    c_drv = 2'b01; c_fix_on = 1; c_fix_lvl = 1; frame(256); frame(256);  // R5
    c_fix_lvl = 0; frame(256); frame(256);
    c_fix_on = 0; frame(256);
    c_par_on = 1; frame(256); frame(256); frame(256);          // R2
    c_par_odd = 1; frame(256); frame(256);                     // R3
    c_par_ext = 1; frame(256); frame(256); frame(256);          // R4
    c_par_odd = 0; frame(256); frame(256);
    frame(100); frame(256); frame(256);                         // R8 short frame
    gap(40); frame(256); frame(256);                            // R8 missing pulse
    frame(256); gap(300); frame(256); frame(256);
    c_drv = 2'b10; frame(256);                                  // R9 unused codes
    c_drv = 2'b11; frame(256);
    c_drv = 2'b00; frame(256);
    cyc(1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule